// File: doc/BRIEF.md
# Four-Byte Master Data Buffer

This block is the byte store between a processor-facing register port and a two-wire serial bus master engine. The processor pushes bytes that are waiting to be sent and pops bytes that have arrived. The block holds up to four bytes in arrival order and reports its fill level. It drives two status flags: one says the buffer holds at least one byte, the other says it holds four.

The buffer is not a ring. A pop always takes the byte at position 0, and every remaining byte moves down one place. A pop on an empty buffer returns all ones and changes nothing. A push into a full buffer is dropped without any notice. When a receive transfer finishes, the engine can load all four positions at once and set the fill level to the number of bytes it received. A flush empties the buffer, zeroes its storage and clears both flags.

When several controls arrive in the same cycle, flush wins, then engine load, then the pair pop and push. When pop and push arrive together, the pop is done first and the push second.

Top module: `mdata_buf`

## Requirements
- R1: After reset the fill level is 0, both flags are low and the pop data output reads 0xFF.
- R2: A push stores the byte behind the last valid byte and raises the fill level by one. A push when the level is 4 changes neither the level nor the stored bytes.
- R3: While the level is 0, the pop data output reads 0xFF, and a pop changes neither the level nor the flags.
- R4: While the level is nonzero, the pop data output shows the byte at position 0 (the oldest byte). A pop removes it, moves every later byte down one position and lowers the level by one.
- R5: has_data_o is high exactly when the level is at least 1. full_o is high exactly when the level is 4. Both flags update in the same cycle as the level.
- R6: A flush sets the level to 0, zeroes all four positions and clears both flags. In the same cycle it overrides push, pop and load.
- R7: An engine load sets the level to load_count_i, saturated at 4. Byte k of load_data_i (bits 8k+7 down to 8k) goes to position k, so position 0 is popped first. The flags follow the new level. A load overrides push and pop in the same cycle.
- R8: When pop and push arrive in the same cycle, the pop is done first and the push second. At level 4 both take effect and the level stays 4. At level 0 the pop reads 0xFF and the pushed byte is stored, giving level 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Append push_data_i behind the last valid byte |
| push_data_i | input | 8 | Byte to append |
| pop_i | input | 1 | Remove the byte at position 0 |
| pop_data_o | output | 8 | Byte at position 0, or 0xFF when empty |
| flush_i | input | 1 | Empty the buffer and zero its storage |
| load_i | input | 1 | Engine bulk load after a receive transfer |
| load_count_i | input | 3 | Number of received bytes, saturated at 4 |
| load_data_i | input | 32 | Received bytes, byte k at bits 8k+7..8k |
| level_o | output | 3 | Number of valid bytes, 0 to 4 |
| has_data_o | output | 1 | At least one byte held |
| full_o | output | 1 | Four bytes held |

## Verification
A wrong level shows in the same cycle on level_o and on the two flags. On later pops it shows again, as a 0xFF where a byte was expected, or as a stale byte where 0xFF was expected. A shift or placement error inside storage stays hidden until that position reaches position 0. This can take up to three more pops, so every scenario drains the buffer completely and checks the order. The flags are held in their own registers, separate from the level, so they are compared against the level on every clock edge.

// File: rtl/mdata_buf.sv
module mdata_buf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push_i,
  input  logic [DATA_W-1:0]       push_data_i,
  input  logic                    pop_i,
  output logic [DATA_W-1:0]       pop_data_o,
  input  logic                    flush_i,
  input  logic                    load_i,
  input  logic [CNT_W-1:0]        load_count_i,
  input  logic [DEPTH*DATA_W-1:0] load_data_i,
  output logic [CNT_W-1:0]        level_o,
  output logic                    has_data_o,
  output logic                    full_o
);

  localparam logic [CNT_W-1:0] LVL_FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] LVL_LAST = CNT_W'(DEPTH - 1);

  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [DATA_W-1:0] slot_d [DEPTH];
  logic [CNT_W-1:0]  lvl_q, lvl_d, lvl_mid;
  logic              has_q, has_d, full_q, full_d;
  logic [CNT_W-1:0]  load_lvl;

  assign load_lvl   = (load_count_i > LVL_FULL) ? LVL_FULL : load_count_i;
  assign pop_data_o = (lvl_q == '0) ? '1 : slot_q[0];
  assign level_o    = lvl_q;
  assign has_data_o = has_q;
  assign full_o     = full_q;

  always_comb begin
    for (int k = 0; k < DEPTH; k++) slot_d[k] = slot_q[k];
    lvl_d   = lvl_q;
    has_d   = has_q;
    full_d  = full_q;
    lvl_mid = lvl_q;
    if (flush_i) begin
      for (int k = 0; k < DEPTH; k++) slot_d[k] = '0;
      lvl_d  = '0;
      has_d  = 1'b0;
      full_d = 1'b0;
    end else if (load_i) begin
      for (int k = 0; k < DEPTH; k++) slot_d[k] = load_data_i[k*DATA_W +: DATA_W];
      lvl_d  = load_lvl;
      has_d  = (load_lvl != '0);
      full_d = (load_lvl == LVL_FULL);
    end else begin
      if (pop_i && lvl_q != '0) begin
        if (lvl_q == LVL_FULL) full_d = 1'b0;
        if (lvl_q == CNT_W'(1)) has_d = 1'b0;
        for (int k = 0; k < DEPTH - 1; k++) slot_d[k] = slot_q[k+1];
        lvl_mid = lvl_q - CNT_W'(1);
      end
      lvl_d = lvl_mid;
      if (push_i && lvl_mid != LVL_FULL) begin
        for (int k = 0; k < DEPTH; k++)
          if (CNT_W'(k) == lvl_mid) slot_d[k] = push_data_i;
        if (lvl_mid == LVL_LAST) full_d = 1'b1;
        if (lvl_mid == '0) has_d = 1'b1;
        lvl_d = lvl_mid + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) slot_q[k] <= '0;
      lvl_q  <= '0;
      has_q  <= 1'b0;
      full_q <= 1'b0;
    end else begin
      for (int k = 0; k < DEPTH; k++) slot_q[k] <= slot_d[k];
      lvl_q  <= lvl_d;
      has_q  <= has_d;
      full_q <= full_d;
    end
  end

  // R5
  has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    has_q == (lvl_q != '0));

  // R5
  full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_q == (lvl_q == LVL_FULL));

  // R2
  push_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q == LVL_FULL && push_i && !pop_i && !flush_i && !load_i)
    |=> (lvl_q == LVL_FULL && $stable(pop_data_o)));

  // R3
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q == '0 && pop_i && !push_i && !flush_i && !load_i)
    |=> (lvl_q == '0 && !has_q));

  // R4
  pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != '0 && pop_i && !push_i && !flush_i && !load_i)
    |=> (lvl_q == $past(lvl_q) - CNT_W'(1)));

  // R6
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (lvl_q == '0 && !has_q && !full_q && pop_data_o == '1));

  // R7
  load_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !flush_i) |=> (lvl_q == $past(load_lvl)));

  // R8
  swap_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q == LVL_FULL && push_i && pop_i && !flush_i && !load_i)
    |=> (lvl_q == LVL_FULL && full_q));

endmodule

// File: tb/mdata_buf_tb.sv
`timescale 1ns/1ps
module mdata_buf_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 1'b0, pop_i = 1'b0, flush_i = 1'b0, load_i = 1'b0;
  logic [7:0]  push_data_i = '0;
  logic [2:0]  load_count_i = '0;
  logic [31:0] load_data_i = '0;
  logic [7:0]  pop_data_o;
  logic [2:0]  level_o;
  logic        has_data_o, full_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mdata_buf dut_i (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
    .pop_i(pop_i), .pop_data_o(pop_data_o), .flush_i(flush_i), .load_i(load_i),
    .load_count_i(load_count_i), .load_data_i(load_data_i), .level_o(level_o),
    .has_data_o(has_data_o), .full_o(full_o));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic state(string req, int lvl);
    chk(req, level_o, lvl);
    chk({req, " has"}, has_data_o, lvl != 0);
    chk({req, " full"}, full_o, lvl == 4);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    push_i = 0; pop_i = 0; flush_i = 0; load_i = 0;
  endtask

  task automatic push(logic [7:0] d);
    push_i = 1; push_data_i = d; step();
  endtask

  task automatic pop_expect(string req, int exp);
    #0.5 chk(req, pop_data_o, exp);
    pop_i = 1; step();
  endtask

  task automatic t_reset();
    state("R1", 0);
    chk("R1 data", pop_data_o, 8'hFF);
  endtask

  task automatic t_fill_drain();
    push(8'hA1); state("R2 R5", 1);
    push(8'hA2); push(8'hA3); state("R2", 3);
    push(8'hA4); state("R2 R5", 4);
    push(8'h55); state("R2 drop", 4);
    pop_expect("R4", 8'hA1); state("R4", 3);
    pop_expect("R4", 8'hA2); pop_expect("R4", 8'hA3);
    pop_expect("R4", 8'hA4); state("R4 R5", 0);
  endtask

  task automatic t_empty_pop();
    pop_expect("R3", 8'hFF); state("R3", 0);
    pop_expect("R3", 8'hFF); state("R3", 0);
  endtask

  task automatic t_swap();
    push(8'h11); push(8'h22); push(8'h33); push(8'h44);
    #0.5 chk("R8 head", pop_data_o, 8'h11);
    pop_i = 1; push_i = 1; push_data_i = 8'h55; step();
    state("R8 full", 4);
    pop_expect("R8", 8'h22); pop_expect("R8", 8'h33);
    pop_expect("R8", 8'h44); pop_expect("R8", 8'h55);
    state("R8", 0);
    #0.5 chk("R8 empty", pop_data_o, 8'hFF);
    pop_i = 1; push_i = 1; push_data_i = 8'h66; step();
    state("R8 empty", 1);
    pop_expect("R8", 8'h66);
  endtask

  task automatic t_flush();
    push(8'h01); push(8'h02);
    flush_i = 1; push_i = 1; push_data_i = 8'h77; pop_i = 1; load_i = 1;
    load_count_i = 3'd3; step();
    state("R6", 0);
    chk("R6 data", pop_data_o, 8'hFF);
    push(8'h09); pop_expect("R6", 8'h09); state("R6", 0);
  endtask

  task automatic t_load();
    for (int n = 0; n < 8; n++) begin
      int exp = (n > 4) ? 4 : n;
      push(8'hEE);
      load_i = 1; load_count_i = 3'(n); load_data_i = 32'hD4C3B2A1;
      push_i = 1; pop_i = 1; step();
      state("R7", exp);
      for (int k = 0; k < exp; k++) pop_expect("R7", 8'hA1 + 8'h11 * k);
      pop_expect("R7 end", 8'hFF);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill_drain();
    t_empty_pop();
    t_swap();
    t_flush();
    t_load();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule